// File: doc/BRIEF.md
# Burst-of-Four Double-Rate SRAM Core

This block is a synthesizable behavioural model of a pipelined static memory that moves every access as a burst of four words. Both edges of the memory clock are folded into one clock domain. Each clock cycle carries two data words on each side: a first-half word (`_a`) and a second-half word (`_b`). A controller starts an access by pulling the load strobe low at a rising edge and choosing read or write. It supplies write data on the two cycles after the address edge and collects read data from a pair of valid-qualified half-word outputs.

A write's address and data are kept in a posted-write register and are not placed in the array straight away. They are committed to the array when the next write starts delivering data. A read merges the array with that register, word by word and lane by lane, so posting is never visible at the ports.

The read stream has no back-pressure. There is no ready signal, and a word flagged valid must be taken in the cycle it is shown. Write data is accepted only on the two fixed cycles after a write's address edge.

A strap input selects the read latency: one cycle, or one and a half cycles. A parameter replaces the address-seeded burst start with a start that is always slot 0. In that variant the two low address bits are ignored.

Top module: `ddr_burst_sram`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, both read valids are 0, both read data buses are 0 and `seq_err` is 0.
- R2: An access is requested when `ld_n` is 0 at a rising edge. `rw_rd`=1 requests a read and `rw_rd`=0 requests a write, both at address `addr`.
- R3: Word k (k = 0..3) of a burst uses word address {`addr[AW-1:2]`, (`addr[1:0]`+k) mod 4}. The low two bits wrap inside the aligned group of four.
- R4: Write words 0 and 1 are taken from `wd_a` and `wd_b` at the first rising edge after the address edge. Words 2 and 3 are taken from the same pins at the edge after that.
- R5: Byte lane i is bits [i*LANE_W +: LANE_W]. Lane i of a word is written only when bit i of that word's active-low select (`wsel_n_a` or `wsel_n_b`) is 0. A lane left unselected keeps its earlier contents.
- R6: With `lat15`=0, a read accepted at edge t shows words 0 and 1 on `rd_a` and `rd_b` in the cycle after edge t+1. It shows words 2 and 3 in the cycle after edge t+2.
- R7: With `lat15`=1, a read accepted at edge t shows word 0 on `rd_b` after edge t+1, words 1 and 2 on `rd_a` and `rd_b` after edge t+2, and word 3 on `rd_a` after edge t+3.
- R8: A load request at the edge right after an accepted load is ignored. It produces no read output and writes nothing.
- R9: A read always returns the newest written data, lane by lane, including data of a write whose burst ended at the edge the read was accepted.
- R10: A write requested two edges after an accepted read is rejected. It writes nothing, and `seq_err` is 1 for exactly the one cycle after that edge.
- R11: A half with no word to show has its valid at 0 and its data bus at 0. This includes the cycle after a burst ends with no new read.
- R12: Reads accepted on every other edge give a gapless stream. With `lat15`=1, one cycle carries the last word of one burst on `rd_a` and the first word of the next on `rd_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lat15 | input | 1 | Latency strap: 1 = one-and-a-half-cycle read latency, 0 = one cycle |
| ld_n | input | 1 | Load strobe, active low |
| rw_rd | input | 1 | Access direction for a load: 1 read, 0 write |
| addr | input | AW | Word address of the burst |
| wd_a | input | LANE_W*LANES | First-half write word |
| wd_b | input | LANE_W*LANES | Second-half write word |
| wsel_n_a | input | LANES | Active-low lane selects for `wd_a` |
| wsel_n_b | input | LANES | Active-low lane selects for `wd_b` |
| rd_a | output | LANE_W*LANES | First-half read word, 0 when not valid |
| rd_a_vld | output | 1 | `rd_a` carries a read word |
| rd_b | output | LANE_W*LANES | Second-half read word, 0 when not valid |
| rd_b_vld | output | 1 | `rd_b` carries a read word |
| seq_err | output | 1 | One-cycle flag for a write rejected for coming too soon after a read |

## Verification
In the one-and-a-half-cycle mode, two reads accepted two edges apart share one output cycle. The held last word of the older burst appears on `rd_a` while the first word of the newer burst appears on `rd_b`. The stimulus table provokes this by issuing reads back to back. The bench tags every expected half-word with the burst it belongs to, so a cycle whose halves come from two bursts is judged under R12 and any slip or overwrite between them shows up. A second overlap is a load ignored during a write's data cycle while the posted register is being filled. The bench injects this overlap and judges it by later reads of the poked address.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;
  localparam int BURST_WORDS = 4;

  // slot of burst word k when the burst starts at slot base
  function automatic logic [1:0] burst_slot(input logic [1:0] base, input int unsigned k);
    return base + 2'(k);
  endfunction
endpackage

// File: rtl/ddrb_ctrl.sv
module ddrb_ctrl
  import ddrb_pkg::*;
#(
  parameter int AW         = 5,
  parameter bit ZERO_START = 1'b0,
  localparam int BW        = AW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic          rw_rd,
  input  logic [AW-1:0] addr,
  output logic          rd_go,
  output logic          wr_go,
  output logic          rd_ph1,
  output logic          rd_ph2,
  output logic          wr_ph1,
  output logic          wr_ph2,
  output logic [BW-1:0] blk,
  output logic [1:0]    start,
  output logic          err
);
  logic acc_d1, rd_d1, rd_d2, wr_d1, wr_d2;
  logic load, clash, accept;
  logic [1:0] seed;

  assign load   = rst_n && !ld_n;
  // a write two edges after an accepted read would collide with its output
  assign clash  = load && !rw_rd && !acc_d1 && rd_d2;
  assign accept = load && !acc_d1 && !clash;
  assign rd_go  = accept && rw_rd;
  assign wr_go  = accept && !rw_rd;

  generate
    if (ZERO_START) begin : g_fixed
      assign seed = 2'b00;
    end else begin : g_linear
      assign seed = addr[1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_d1 <= 1'b0;
      rd_d1  <= 1'b0;
      rd_d2  <= 1'b0;
      wr_d1  <= 1'b0;
      wr_d2  <= 1'b0;
      err    <= 1'b0;
      blk    <= '0;
      start  <= '0;
    end else begin
      acc_d1 <= accept;
      rd_d1  <= rd_go;
      rd_d2  <= rd_d1;
      wr_d1  <= wr_go;
      wr_d2  <= wr_d1;
      err    <= clash;
      if (accept) begin
        blk   <= addr[AW-1:2];
        start <= seed;
      end
    end
  end

  assign rd_ph1 = rd_d1;
  assign rd_ph2 = rd_d2;
  assign wr_ph1 = wr_d1;
  assign wr_ph2 = wr_d2;
endmodule

// File: rtl/ddrb_store.sv
module ddrb_store
  import ddrb_pkg::*;
#(
  parameter int LANE_W  = 9,
  parameter int LANES   = 2,
  parameter int AW      = 5,
  localparam int DW     = LANE_W * LANES,
  localparam int BW     = AW - 2,
  localparam int DEPTH  = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ph1,
  input  logic             wr_ph2,
  input  logic [BW-1:0]    blk,
  input  logic [1:0]       start,
  input  logic [DW-1:0]    d_a,
  input  logic [DW-1:0]    d_b,
  input  logic [LANES-1:0] sel_n_a,
  input  logic [LANES-1:0] sel_n_b,
  input  logic [1:0]       rd_slot,
  output logic [DW-1:0]    rd_w0,
  output logic [DW-1:0]    rd_w1
);
  logic [DW-1:0]    mem   [DEPTH];
  logic [DW-1:0]    p_dat [BURST_WORDS];
  logic [LANES-1:0] p_msk [BURST_WORDS];
  logic             pv;
  logic [BW-1:0]    p_blk;

  // posted-write register: filled over the two data cycles of a write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv    <= 1'b0;
      p_blk <= '0;
      for (int i = 0; i < BURST_WORDS; i++) begin
        p_dat[i] <= '0;
        p_msk[i] <= '0;
      end
    end else begin
      if (wr_ph1) begin
        pv    <= 1'b1;
        p_blk <= blk;
        for (int i = 0; i < BURST_WORDS; i++) p_msk[i] <= '0;
        p_dat[burst_slot(start, 0)] <= d_a;
        p_msk[burst_slot(start, 0)] <= ~sel_n_a;
        p_dat[burst_slot(start, 1)] <= d_b;
        p_msk[burst_slot(start, 1)] <= ~sel_n_b;
      end
      if (wr_ph2) begin
        p_dat[burst_slot(start, 2)] <= d_a;
        p_msk[burst_slot(start, 2)] <= ~sel_n_a;
        p_dat[burst_slot(start, 3)] <= d_b;
        p_msk[burst_slot(start, 3)] <= ~sel_n_b;
      end
    end
  end

  // the previous posted burst goes to the array when the next write delivers data
  always_ff @(posedge clk) begin
    if (rst_n && wr_ph1 && pv) begin
      for (int i = 0; i < BURST_WORDS; i++) begin
        for (int l = 0; l < LANES; l++) begin
          if (p_msk[i][l]) mem[{p_blk, 2'(i)}][l*LANE_W +: LANE_W] <= p_dat[i][l*LANE_W +: LANE_W];
        end
      end
    end
  end

  logic          hit;
  logic [1:0]    slot1;
  logic [DW-1:0] arr0, arr1;

  assign hit   = pv && (p_blk == blk);
  assign slot1 = burst_slot(rd_slot, 1);
  assign arr0  = mem[{blk, rd_slot}];
  assign arr1  = mem[{blk, slot1}];

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign rd_w0[l*LANE_W +: LANE_W] = (hit && p_msk[rd_slot][l]) ?
                                         p_dat[rd_slot][l*LANE_W +: LANE_W] : arr0[l*LANE_W +: LANE_W];
      assign rd_w1[l*LANE_W +: LANE_W] = (hit && p_msk[slot1][l]) ?
                                         p_dat[slot1][l*LANE_W +: LANE_W] : arr1[l*LANE_W +: LANE_W];
    end
  endgenerate

  // R4
  posted_fill_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ph2 |-> pv);
endmodule

// File: rtl/ddrb_rdout.sv
module ddrb_rdout #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat15,
  input  logic          fire,
  input  logic [DW-1:0] w0,
  input  logic [DW-1:0] w1,
  output logic [DW-1:0] q_a,
  output logic          v_a,
  output logic [DW-1:0] q_b,
  output logic          v_b
);
  logic [DW-1:0] s_a, s_b, h_b;
  logic          s_v, h_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_a <= '0;
      s_b <= '0;
      h_b <= '0;
      s_v <= 1'b0;
      h_v <= 1'b0;
    end else begin
      s_v <= fire;
      if (fire) begin
        s_a <= w0;
        s_b <= w1;
      end
      h_v <= s_v;
      h_b <= s_b;
    end
  end

  // half-cycle shift: the held second word moves to the next first half
  always_comb begin
    if (lat15) begin
      v_a = h_v;
      q_a = h_v ? h_b : '0;
      v_b = s_v;
      q_b = s_v ? s_a : '0;
    end else begin
      v_a = s_v;
      q_a = s_v ? s_a : '0;
      v_b = s_v;
      q_b = s_v ? s_b : '0;
    end
  end
endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram
  import ddrb_pkg::*;
#(
  parameter int LANE_W     = 9,
  parameter int LANES      = 2,
  parameter int AW         = 5,
  parameter bit ZERO_START = 1'b0,
  localparam int DW        = LANE_W * LANES,
  localparam int BW        = AW - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lat15,
  input  logic             ld_n,
  input  logic             rw_rd,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wd_a,
  input  logic [DW-1:0]    wd_b,
  input  logic [LANES-1:0] wsel_n_a,
  input  logic [LANES-1:0] wsel_n_b,
  output logic [DW-1:0]    rd_a,
  output logic             rd_a_vld,
  output logic [DW-1:0]    rd_b,
  output logic             rd_b_vld,
  output logic             seq_err
);
  logic          rd_go, wr_go, rd_ph1, rd_ph2, wr_ph1, wr_ph2;
  logic [BW-1:0] blk;
  logic [1:0]    start, rd_slot;
  logic [DW-1:0] w0, w1;

  ddrb_ctrl #(.AW(AW), .ZERO_START(ZERO_START)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw_rd(rw_rd), .addr(addr),
    .rd_go(rd_go), .wr_go(wr_go), .rd_ph1(rd_ph1), .rd_ph2(rd_ph2),
    .wr_ph1(wr_ph1), .wr_ph2(wr_ph2), .blk(blk), .start(start), .err(seq_err)
  );

  assign rd_slot = burst_slot(start, rd_ph2 ? 2 : 0);

  ddrb_store #(.LANE_W(LANE_W), .LANES(LANES), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_ph1(wr_ph1), .wr_ph2(wr_ph2), .blk(blk),
    .start(start), .d_a(wd_a), .d_b(wd_b), .sel_n_a(wsel_n_a), .sel_n_b(wsel_n_b),
    .rd_slot(rd_slot), .rd_w0(w0), .rd_w1(w1)
  );

  ddrb_rdout #(.DW(DW)) u_rdout (
    .clk(clk), .rst_n(rst_n), .lat15(lat15), .fire(rd_ph1 || rd_ph2),
    .w0(w0), .w1(w1), .q_a(rd_a), .v_a(rd_a_vld), .q_b(rd_b), .v_b(rd_b_vld)
  );

  // R8 R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_ph1, rd_ph2, wr_ph1, wr_ph2}));

  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> $past(!ld_n && !rw_rd));

  // R6
  lat1_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat15 && $past(rd_go, 2)) |-> (rd_a_vld && rd_b_vld));

  // R7
  lat15_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat15 && $past(rd_go, 2)) |-> rd_b_vld);
endmodule

// File: tb/sim_ddr_burst_sram.sv
module sim_ddr_burst_sram;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int AW = 5;
  localparam int DW = LW * NL;
  localparam int NE = 1024;
  localparam int NV = 12;

  logic clk = 1'b0, rst_n = 1'b0, lat15 = 1'b0, ld_n = 1'b1, rw_rd = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd_a = '0, wd_b = '0;
  logic [NL-1:0] wsel_n_a = '1, wsel_n_b = '1;
  logic [DW-1:0] rd_a, rd_b;
  logic rd_a_vld, rd_b_vld, seq_err;

  ddr_burst_sram #(.LANE_W(LW), .LANES(NL), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .lat15(lat15), .ld_n(ld_n), .rw_rd(rw_rd), .addr(addr),
    .wd_a(wd_a), .wd_b(wd_b), .wsel_n_a(wsel_n_a), .wsel_n_b(wsel_n_b),
    .rd_a(rd_a), .rd_a_vld(rd_a_vld), .rd_b(rd_b), .rd_b_vld(rd_b_vld), .seq_err(seq_err)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0, bid = 0;
  bit chk_on = 1'b0, done = 1'b0;
  string tag = "R1";
  logic [DW-1:0] gm [1 << AW];
  logic [DW-1:0] ea [NE];
  logic [DW-1:0] eb [NE];
  bit eva [NE];
  bit evb [NE];
  int ida [NE];
  int idb [NE];

  // {write, poke, addr, seed, lane mask (word k lane l at bit k*NL+l)}
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 2'd0, 5'd5,  4'd1, 8'hFF},   // R2 R3 R4: start slot 1
    {1'b0, 2'd0, 5'd5,  4'd0, 8'h00},   // R9: served from posted register
    {1'b0, 2'd0, 5'd6,  4'd0, 8'h00},   // R12: back-to-back read
    {1'b1, 2'd1, 5'd11, 4'd2, 8'hFF},   // R8: read load during data cycle
    {1'b1, 2'd2, 5'd8,  4'd3, 8'h69},   // R5 partial lanes, R8 write load poke
    {1'b0, 2'd0, 5'd8,  4'd0, 8'h00},
    {1'b0, 2'd0, 5'd11, 4'd0, 8'h00},   // R3 wrap from slot 3
    {1'b0, 2'd0, 5'd20, 4'd0, 8'h00},   // R8: poked address untouched
    {1'b1, 2'd0, 5'd12, 4'd4, 8'h0F},
    {1'b1, 2'd0, 5'd13, 4'd5, 8'hF0},   // R9: commit of previous burst
    {1'b0, 2'd0, 5'd14, 4'd0, 8'h00},
    {1'b0, 2'd0, 5'd5,  4'd0, 8'h00}
  };

  function automatic logic [DW-1:0] mk(input int s, input int k);
    return DW'((s * 13 + k * 5 + 1) * 2731);
  endfunction

  task automatic check(input string t, input logic [DW:0] act, input logic [DW:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", t, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      int i;
      i = cyc % NE;
      if (eva[i]) check($sformatf("%s %s", (evb[i] && ida[i] != idb[i]) ? "R12" : (lat15 ? "R7" : "R6"), tag),
                        {rd_a_vld, rd_a}, {1'b1, ea[i]});
      else check("R11 rd_a idle", {rd_a_vld, rd_a}, '0);
      if (evb[i]) check($sformatf("%s %s", lat15 ? "R7" : "R6", tag), {rd_b_vld, rd_b}, {1'b1, eb[i]});
      else check("R11 rd_b idle", {rd_b_vld, rd_b}, '0);
      eva[i] = 1'b0;
      evb[i] = 1'b0;
    end
  end

  task automatic sched(input int c, input bit half, input logic [DW-1:0] v, input int id);
    if (!half) begin ea[c % NE] = v; eva[c % NE] = 1'b1; ida[c % NE] = id; end
    else begin eb[c % NE] = v; evb[c % NE] = 1'b1; idb[c % NE] = id; end
  endtask

  task automatic idle(input int n);
    ld_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_burst(input int a);
    logic [DW-1:0] w [4];
    for (int k = 0; k < 4; k++) w[k] = gm[(a & ~3) | ((a + k) & 3)];
    bid++;
    if (!lat15) begin
      sched(cyc + 2, 0, w[0], bid); sched(cyc + 2, 1, w[1], bid);
      sched(cyc + 3, 0, w[2], bid); sched(cyc + 3, 1, w[3], bid);
    end else begin
      sched(cyc + 2, 1, w[0], bid); sched(cyc + 3, 0, w[1], bid);
      sched(cyc + 3, 1, w[2], bid); sched(cyc + 4, 0, w[3], bid);
    end
    ld_n = 1'b0; rw_rd = 1'b1; addr = AW'(a);
    @(negedge clk);
    ld_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_burst(input int a, input int s, input logic [4*NL-1:0] m, input int poke);
    logic [DW-1:0] v;
    ld_n = 1'b0; rw_rd = 1'b0; addr = AW'(a);
    @(negedge clk);
    if (poke != 0) begin ld_n = 1'b0; rw_rd = (poke == 1); addr = AW'(20); end
    else ld_n = 1'b1;
    wd_a = mk(s, 0); wd_b = mk(s, 1);
    wsel_n_a = ~m[NL-1:0]; wsel_n_b = ~m[2*NL-1:NL];
    @(negedge clk);
    ld_n = 1'b1;
    wd_a = mk(s, 2); wd_b = mk(s, 3);
    wsel_n_a = ~m[3*NL-1:2*NL]; wsel_n_b = ~m[4*NL-1:3*NL];
    for (int k = 0; k < 4; k++) begin
      v = mk(s, k);
      for (int l = 0; l < NL; l++)
        if (m[k*NL + l]) gm[(a & ~3) | ((a + k) & 3)][l*LW +: LW] = v[l*LW +: LW];
    end
  endtask

  task automatic run_pass(input bit mode);
    bit prev_rd;
    chk_on = 1'b0;
    rst_n = 1'b0;
    lat15 = mode;
    idle(3);
    tag = "R1";
    check("R1 reset a", {rd_a_vld, rd_a}, '0);
    check("R1 reset b", {rd_b_vld, rd_b}, '0);
    check("R1 reset err", {{DW{1'b0}}, seq_err}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release err", {{DW{1'b0}}, seq_err}, '0);
    chk_on = 1'b1;
    for (int b = 0; b < (1 << (AW - 2)); b++) wr_burst(b * 4, 20 + b, '1, 0);
    prev_rd = 1'b0;
    for (int n = 0; n < NV; n++) begin
      if (VEC[n][19]) begin
        if (prev_rd) idle(1);
        tag = "R2 R4 R5 R8";
        wr_burst(int'(VEC[n][16:12]), int'(VEC[n][11:8]), VEC[n][7:0], int'(VEC[n][18:17]));
        prev_rd = 1'b0;
      end else begin
        tag = "R2 R3 R9";
        rd_burst(int'(VEC[n][16:12]));
        prev_rd = 1'b1;
      end
    end
    idle(5);
  endtask

  initial begin
    for (int i = 0; i < NE; i++) begin eva[i] = 1'b0; evb[i] = 1'b0; ida[i] = 0; idb[i] = 0; end
    for (int i = 0; i < (1 << AW); i++) gm[i] = '0;
    run_pass(1'b0);
    // R10: write two edges after a read is refused and flagged for one cycle
    tag = "R10";
    rd_burst(1);
    ld_n = 1'b0; rw_rd = 1'b0; addr = AW'(1);
    wd_a = '1; wd_b = '1; wsel_n_a = '0; wsel_n_b = '0;
    @(negedge clk);
    ld_n = 1'b1;
    check("R10 flag raised", {{DW{1'b0}}, seq_err}, {{DW{1'b0}}, 1'b1});
    @(negedge clk);
    check("R10 flag one cycle", {{DW{1'b0}}, seq_err}, '0);
    idle(1);
    rd_burst(1);
    idle(5);
    run_pass(1'b1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule